// File: doc/BRIEF.md
# Back-Porch Clamp Window Generator

This block produces a per-line clamp-enable window in the pixel clock domain for a video capture front end. The window is timed from the trailing edge of the already-synchronized horizontal sync, so that it falls on the black reference of the back porch and never on the sync tip. A delay value sets how many pixel clocks pass after that edge before the window opens. A length value sets how many pixel clocks it stays open.

Alongside the window, the block drives one clamp target code for each of three colour channels. A select bit per channel chooses between a ground target, used for RGB black levels, and a midscale target, used for colour-difference signals whose reference sits at the middle of the converter range. The clamp enable is a flip-flop output, so it can drive analog switch control without glitches.

Top module: `clamp_window_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it, `clamp_en` is 0 and every field of `clamp_target` is 0.
- R2: With `hs_pol` = 1 (sync active high), the trailing edge is a 1-to-0 transition of `hsync_in`. The 0-to-1 (leading) transition starts no window.
- R3: With `hs_pol` = 0 (sync active low), the trailing edge is a 0-to-1 transition of `hsync_in`. The 1-to-0 transition starts no window.
- R4: A trailing edge is first seen at the clock edge E where `hsync_in` is sampled inactive after being sampled active. With delay P and length D, `clamp_en` is high after clock edges E+P through E+P+D-1 and low otherwise.
- R5: Boundary values behave per R4. P = 0 raises `clamp_en` right after edge E. P = 255 and D = 255 give the full 8-bit delay and length.
- R6: A length of 0 produces no clamp pulse on that line.
- R7: A trailing edge that arrives while a window is pending or open cancels that window and restarts timing from the new edge.
- R8: `placement` and `duration` are taken at the trailing edge. Changes made later in the line take effect only from the next trailing edge.
- R9: Bit i of `mid_sel` selects the target for channel i, carried in `clamp_target[8i+7:8i]`. A value of 1 gives code 128 and a value of 0 gives code 0. The output follows the select one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, already synchronized to `clk` |
| hs_pol | input | 1 | Sync sense: 1 = active high, 0 = active low |
| placement | input | 8 | Pixel clocks from the trailing edge to the window start |
| duration | input | 8 | Window length in pixel clocks; 0 disables the window |
| mid_sel | input | 3 | Per-channel target select: 1 = midscale, 0 = ground |
| clamp_en | output | 1 | Registered clamp window |
| clamp_target | output | 24 | Three 8-bit clamp target codes, channel 0 in the low byte |

## Verification
The sync is driven as regular lines with both sync senses. This shows that only the trailing transition starts a window and that the leading one does not. Delay and length are swept through zero, small and full-scale values, which separates an off-by-one in the wait count from one in the open count. Lines shorter than the window check cancellation and restart. Changes to the delay and length in the middle of a line show whether these values are captured at the edge or used live. Several select patterns confirm that each channel's target lands in its own byte.

// File: rtl/clamp_gen_pkg.sv
package clamp_gen_pkg;
  typedef enum logic [1:0] {
    CG_IDLE   = 2'd0,
    CG_WAIT   = 2'd1,
    CG_ACTIVE = 2'd2
  } cg_state_e;
endpackage

// File: rtl/clamp_sync_edge.sv
// Converts sync to "active" sense and flags the trailing transition.
module clamp_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic hsync_in,
  input  logic hs_pol,
  output logic trail
);
  logic act;
  logic act_q;

  assign act = hs_pol ? hsync_in : ~hsync_in;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  // active in the previous sample, inactive now
  assign trail = act_q & ~act & ~rst;
endmodule

// File: rtl/clamp_window_fsm.sv
// Wait / open sequencer with a registered enable.
module clamp_window_fsm
  import clamp_gen_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEF_DUR   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trail,
  input  logic [CNT_W-1:0] placement,
  input  logic [CNT_W-1:0] duration,
  output logic             clamp_en
);
  localparam logic [CNT_W-1:0] DUR_RST = CNT_W'(DEF_DUR);

  cg_state_e        state_q, state_n;
  logic [CNT_W-1:0] wcnt_q, wcnt_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [CNT_W-1:0] dur_q, dur_n;

  always_comb begin
    state_n = state_q;
    wcnt_n  = wcnt_q;
    rem_n   = rem_q;
    dur_n   = dur_q;
    if (trail) begin
      dur_n = duration;
      if (duration == '0) begin
        state_n = CG_IDLE;
      end else if (placement == '0) begin
        state_n = CG_ACTIVE;
        rem_n   = duration - 1'b1;
      end else begin
        state_n = CG_WAIT;
        wcnt_n  = placement - 1'b1;
      end
    end else begin
      unique case (state_q)
        CG_WAIT: begin
          if (wcnt_q == '0) begin
            state_n = CG_ACTIVE;
            rem_n   = dur_q - 1'b1;
          end else begin
            wcnt_n = wcnt_q - 1'b1;
          end
        end
        CG_ACTIVE: begin
          if (rem_q == '0) state_n = CG_IDLE;
          else             rem_n   = rem_q - 1'b1;
        end
        default: state_n = CG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CG_IDLE;
      wcnt_q   <= '0;
      rem_q    <= '0;
      dur_q    <= DUR_RST;
      clamp_en <= 1'b0;
    end else begin
      state_q  <= state_n;
      wcnt_q   <= wcnt_n;
      rem_q    <= rem_n;
      dur_q    <= dur_n;
      clamp_en <= (state_n == CG_ACTIVE);
    end
  end
endmodule

// File: rtl/clamp_target_sel.sv
// Registered per-channel target code: ground or midscale.
module clamp_target_sel #(
  parameter int NCH    = 3,
  parameter int CODE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          mid_sel,
  output logic [NCH*CODE_W-1:0]   clamp_target
);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_GND = '0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) clamp_target[ch*CODE_W +: CODE_W] <= '0;
      else     clamp_target[ch*CODE_W +: CODE_W] <= mid_sel[ch] ? CODE_MID : CODE_GND;
    end
  end
endmodule

// File: rtl/clamp_window_gen.sv
module clamp_window_gen #(
  parameter int CNT_W   = 8,
  parameter int NCH     = 3,
  parameter int CODE_W  = 8,
  parameter int DEF_DUR = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hsync_in,
  input  logic                  hs_pol,
  input  logic [CNT_W-1:0]      placement,
  input  logic [CNT_W-1:0]      duration,
  input  logic [NCH-1:0]        mid_sel,
  output logic                  clamp_en,
  output logic [NCH*CODE_W-1:0] clamp_target
);
  logic trail;

  clamp_sync_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .hsync_in (hsync_in),
    .hs_pol   (hs_pol),
    .trail    (trail)
  );

  clamp_window_fsm #(
    .CNT_W   (CNT_W),
    .DEF_DUR (DEF_DUR)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .trail     (trail),
    .placement (placement),
    .duration  (duration),
    .clamp_en  (clamp_en)
  );

  clamp_target_sel #(
    .NCH    (NCH),
    .CODE_W (CODE_W)
  ) u_tgt (
    .clk          (clk),
    .rst          (rst),
    .mid_sel      (mid_sel),
    .clamp_target (clamp_target)
  );
endmodule

// File: rtl/clamp_window_gen_chk.sv
module clamp_window_gen_chk #(
  parameter int CNT_W  = 8,
  parameter int NCH    = 3,
  parameter int CODE_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hsync_in,
  input logic                  hs_pol,
  input logic [CNT_W-1:0]      placement,
  input logic [CNT_W-1:0]      duration,
  input logic [NCH-1:0]        mid_sel,
  input logic                  clamp_en,
  input logic [NCH*CODE_W-1:0] clamp_target
);
  logic            c_act_q;
  logic            armed_q;
  logic [NCH-1:0]  sel_q;
  logic            c_trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_act_q <= 1'b0;
      armed_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      c_act_q <= hs_pol ? hsync_in : ~hsync_in;
      armed_q <= 1'b1;
      sel_q   <= mid_sel;
    end
  end

  assign c_trail = c_act_q & ~(hs_pol ? hsync_in : ~hsync_in);

  function automatic logic [NCH*CODE_W-1:0] want_tgt(input logic [NCH-1:0] s);
    logic [NCH*CODE_W-1:0] v;
    v = '0;
    for (int i = 0; i < NCH; i++)
      v[i*CODE_W +: CODE_W] = s[i] ? (CODE_W'(1) << (CODE_W - 1)) : '0;
    return v;
  endfunction

  // R6: zero length never opens a window
  assert_zero_len_R6: assert property (@(posedge clk) disable iff (rst)
    (c_trail && duration == '0) |=> !clamp_en);

  // R5: zero delay opens the window right after the edge
  assert_zero_delay_R5: assert property (@(posedge clk) disable iff (rst)
    (c_trail && duration != '0 && placement == '0) |=> clamp_en);

  // R7: a new edge with nonzero delay closes any running window
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (c_trail && placement != '0) |=> !clamp_en);

  // R9: targets follow the selects one clock later
  assert_target_R9: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> clamp_target == want_tgt(sel_q));

  // R1: outputs idle on the first clock after reset
  assert_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!clamp_en && clamp_target == '0));
endmodule

bind clamp_window_gen clamp_window_gen_chk #(
  .CNT_W  (CNT_W),
  .NCH    (NCH),
  .CODE_W (CODE_W)
) u_chk (.*);

// File: tb/clamp_window_gen_bench.sv
module clamp_window_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_in = 1'b0;
  logic        hs_pol = 1'b1;
  logic [7:0]  placement = 8'd8;
  logic [7:0]  duration = 8'd20;
  logic [2:0]  mid_sel = 3'b000;
  logic        clamp_en;
  logic [23:0] clamp_target;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  clamp_window_gen u_clamp_window_gen (
    .clk          (clk),
    .rst          (rst),
    .hsync_in     (hsync_in),
    .hs_pol       (hs_pol),
    .placement    (placement),
    .duration     (duration),
    .mid_sel      (mid_sel),
    .clamp_en     (clamp_en),
    .clamp_target (clamp_target)
  );

  // behavioural reference: cycles since the last trailing edge
  bit          m_prev = 0;
  bit          m_valid = 0;
  int          m_since = 0;
  int          m_p = 0;
  int          m_d = 0;
  bit          exp_en = 0;
  logic [23:0] exp_tgt = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_prev = 0; m_valid = 0; m_since = 0;
      exp_en = 0; exp_tgt = '0;
    end else begin
      bit act;
      act = hs_pol ? hsync_in : !hsync_in;
      if (m_prev && !act) begin
        m_valid = 1; m_since = 0;
        m_p = int'(placement); m_d = int'(duration);
      end else if (m_since < 100000) begin
        m_since++;
      end
      m_prev = act;
      exp_en = m_valid && m_d > 0 && m_since >= m_p && m_since < m_p + m_d;
      for (int i = 0; i < 3; i++)
        exp_tgt[i*8 +: 8] = mid_sel[i] ? 8'd128 : 8'd0;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (clamp_en !== exp_en) begin
      fails++;
      $display("FAIL %s clamp_en actual=%0b expected=%0b t=%0t", cur_req, clamp_en, exp_en, $time);
    end
    checks++;
    if (clamp_target !== exp_tgt) begin
      fails++;
      $display("FAIL %s clamp_target actual=%h expected=%h t=%0t", cur_req, clamp_target, exp_tgt, $time);
    end
  end

  task automatic line(input int pw, input int gap);
    hsync_in = hs_pol;
    repeat (pw) @(negedge clk);
    hsync_in = !hs_pol;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: active-high sync, default delay/length
    cur_req = "R2";
    hsync_in = 1'b0;
    repeat (3) line(10, 60);
    cur_req = "R4";
    placement = 8'd3; duration = 8'd7;
    repeat (2) line(6, 30);
    // R3: active-low sync
    cur_req = "R3";
    hsync_in = 1'b1; hs_pol = 1'b0;
    repeat (5) @(negedge clk);
    placement = 8'd8; duration = 8'd20;
    repeat (3) line(10, 60);
    // R5: zero delay, unit and short lengths
    cur_req = "R5";
    placement = 8'd0; duration = 8'd1; line(4, 20);
    duration = 8'd5; line(4, 20);
    placement = 8'd1; duration = 8'd1; line(4, 20);
    // R6: zero length
    cur_req = "R6";
    placement = 8'd0; duration = 8'd0; line(4, 30);
    placement = 8'd5; line(4, 30);
    // R7: lines shorter than the window
    cur_req = "R7";
    placement = 8'd10; duration = 8'd30;
    line(4, 20); line(4, 12); line(4, 60);
    placement = 8'd0; duration = 8'd30;
    line(3, 10); line(3, 50);
    // R8: mid-line change of delay and length
    cur_req = "R8";
    placement = 8'd5; duration = 8'd20;
    line(4, 3);
    placement = 8'd0; duration = 8'd3;
    repeat (60) @(negedge clk);
    line(4, 30);
    // R5: full-scale values
    cur_req = "R5";
    hs_pol = 1'b1; hsync_in = 1'b0;
    repeat (5) @(negedge clk);
    placement = 8'd255; duration = 8'd255;
    line(8, 600);
    // R9: target select patterns
    cur_req = "R9";
    mid_sel = 3'b101; repeat (4) @(negedge clk);
    mid_sel = 3'b010; repeat (4) @(negedge clk);
    mid_sel = 3'b111; placement = 8'd2; duration = 8'd4; line(5, 20);
    mid_sel = 3'b000; repeat (4) @(negedge clk);
    // R1: reset in the middle of a window
    cur_req = "R1";
    mid_sel = 3'b110; placement = 8'd0; duration = 8'd40;
    line(4, 5);
    rst = 1'b1; repeat (3) @(negedge clk);
    rst = 1'b0; repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule